// File: doc/BRIEF.md
# Masked Interrupt Controller with Halt Wake

The block gathers up to 32 interrupt sources into one request line for a CPU, plus a separate wake line that ends a CPU halt. Each source line is a one-cycle pulse from a peripheral. A pulse latches a pending flag for that source whether or not the source is enabled. The request output follows the enabled pending set, and it is gated by a global enable bit. The wake output ignores the global enable. A CPU stopped in halt therefore resumes when an enabled source fires, even with interrupts masked at the global level.

Software reaches the registers over a 16-bit register bus. The bus has a write strobe, a word address, write data and combinational read data. The 32-bit enable and pending-flag registers are each split into a low half and a high half. Sources 0 to 15 sit in the low half and sources 16 to 31 in the high half.

Word addresses:
- 0: enable low half.
- 1: enable high half.
- 2: flag low half.
- 3: flag high half.
- 4: global enable.

Each bit of a half holds the source number minus 16 times the half index. Pending flags are cleared by writing 1 to a bit.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads 0 and both irq_o and wake_o are low.
- R2: A pulse on source line n sets pending flag n whether or not enable bit n is set. The flag is visible on the next cycle: bit n of address 2 for n below 16, bit n-16 of address 3 otherwise.
- R3: A write to address 0 or 1 stores the 16-bit value in the matching enable half, and a read returns that value.
- R4: irq_o is high exactly when the global enable bit is 1 and at least one source has both its enable bit and its pending flag set.
- R5: wake_o is high exactly when at least one source has both its enable bit and its pending flag set, independent of the global enable.
- R6: A write to address 2 or 3 clears each flag bit whose write data bit is 1. Flag bits whose write data bit is 0 are left unchanged.
- R7: When a source pulse and a write-1 clear hit the same flag bit in the same cycle, the flag ends up set.
- R8: A write to an enable half or to the global enable changes irq_o in the cycle right after the write edge, with no further event needed.
- R9: Address 4 stores only write data bit 0 and reads back as that bit with 15 zero bits above it. A write to an address above 4 changes no register, and a read there returns 0.
- R10: irq_o is a level. It drops in the cycle after the last enabled pending flag is cleared, or after the global enable is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Source pulses, one bit per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt request to the CPU |
| wake_o | output | 1 | Halt wake request to the CPU |

## Verification
Sources in both halves are pulsed with their enables clear; the flags must latch while irq_o and wake_o stay low, which separates latching from enabling. Enables are then raised with the global enable off. The bench expects wake_o high and irq_o low, which tells the wake path apart from the request path. The global enable is toggled and flags are cleared with mixed write-1 and write-0 patterns, to show the request is a level that follows those changes. A clear that collides with a new pulse, and writes to an unmapped address, cover the ordering and decode corner cases.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  typedef enum logic [1:0] {RK_EN, RK_FLAG, RK_MASTER, RK_NONE} reg_kind_e;

  // Map: enable halves, flag halves, then one global enable word
  function automatic reg_kind_e kind_of(input int unsigned a, input int unsigned nh);
    if (a < nh)          return RK_EN;
    else if (a < 2 * nh) return RK_FLAG;
    else if (a == 2 * nh) return RK_MASTER;
    return RK_NONE;
  endfunction

  function automatic int unsigned half_of(input int unsigned a, input int unsigned nh);
    return a % nh;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
`timescale 1ns/1ps
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int NUM_HALF = 2,
  localparam int IDX_W   = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic [NUM_HALF-1:0] en_we_o,
  output logic [NUM_HALF-1:0] flag_we_o,
  output logic                master_we_o,
  output reg_kind_e           kind_o,
  output logic [IDX_W-1:0]    half_o
);
  always_comb begin
    kind_o      = kind_of(32'(addr_i), NUM_HALF);
    half_o      = IDX_W'(half_of(32'(addr_i), NUM_HALF));
    master_we_o = we_i && (kind_o == RK_MASTER);
    en_we_o     = '0;
    flag_we_o   = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      en_we_o[h]   = we_i && (kind_o == RK_EN)   && (32'(half_o) == h);
      flag_we_o[h] = we_i && (kind_o == RK_FLAG) && (32'(half_o) == h);
    end
  end
endmodule

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              flag_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] flag_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] en_q, flag_q, clr_mask, flag_d;

  // Set wins over write-1-clear on the same bit
  assign clr_mask = flag_we_i ? wdata_i : '0;
  assign flag_d   = (flag_q & ~clr_mask) | src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign pend_o = |(en_q & flag_q);

  a_r2_src_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((flag_q & $past(src_i)) == $past(src_i)));

  a_r3_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_q == $past(wdata_i)));

  a_r6_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && src_i == '0) |=> (flag_q == ($past(flag_q) & ~$past(wdata_i))));

  a_r6_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: rtl/irqc_eval.sv
`timescale 1ns/1ps
module irqc_eval #(
  parameter int NUM_HALF = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_we_i,
  input  logic                master_wbit_i,
  input  logic [NUM_HALF-1:0] pend_i,
  output logic                master_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic master_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          master_q <= 1'b0;
    else if (master_we_i) master_q <= master_wbit_i;
  end

  assign master_o = master_q;
  assign wake_o   = |pend_i;
  assign irq_o    = master_q && wake_o;

  a_r4_irq_needs_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> master_q);

  a_r5_irq_implies_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);

  a_r9_master_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_we_i |=> (master_q == $past(master_wbit_i)));

  a_r10_master_off_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_we_i && !master_wbit_i) |=> !irq_o);
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int NUM_HALF = NUM_SRC / DATA_W;
  localparam int IDX_W    = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1;

  logic [NUM_HALF-1:0] en_we, flag_we, pend;
  logic                master_we, master_q;
  reg_kind_e           kind;
  logic [IDX_W-1:0]    half;
  logic [DATA_W-1:0]   en_h   [NUM_HALF];
  logic [DATA_W-1:0]   flag_h [NUM_HALF];

  irqc_decode #(.ADDR_W(ADDR_W), .NUM_HALF(NUM_HALF)) u_decode (
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .en_we_o     (en_we),
    .flag_we_o   (flag_we),
    .master_we_o (master_we),
    .kind_o      (kind),
    .half_o      (half)
  );

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_bank
    irqc_bank #(.DATA_W(DATA_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_we_i   (en_we[h]),
      .flag_we_i (flag_we[h]),
      .wdata_i   (bus_wdata_i),
      .src_i     (src_i[h*DATA_W +: DATA_W]),
      .en_o      (en_h[h]),
      .flag_o    (flag_h[h]),
      .pend_o    (pend[h])
    );
  end

  irqc_eval #(.NUM_HALF(NUM_HALF)) u_eval (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .master_we_i   (master_we),
    .master_wbit_i (bus_wdata_i[0]),
    .pend_i        (pend),
    .master_o      (master_q),
    .irq_o         (irq_o),
    .wake_o        (wake_o)
  );

  always_comb begin
    unique case (kind)
      RK_EN:     bus_rdata_o = en_h[half];
      RK_FLAG:   bus_rdata_o = flag_h[half];
      RK_MASTER: bus_rdata_o = {{(DATA_W-1){1'b0}}, master_q};
      default:   bus_rdata_o = '0;
    endcase
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && !wake_o));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == RK_NONE) |-> (bus_rdata_o == '0));
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic [31:0] src = '0;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wake;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {int kind; logic [15:0] exp; string req;} item_t;
  item_t q[$];

  always #2 clk = ~clk;

  irqc_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  // Monitor: compares queued expectations at the falling edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {15'b0, irq} : {15'b0, wake};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1 we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(posedge clk); #1 src = m;
    @(posedge clk); #1 src = '0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] e, input string r);
    @(posedge clk); #1 addr = a;
    q.push_back('{0, e, r});
    @(negedge clk); #1;
  endtask

  task automatic chk_out(input logic i, input logic w, input string r);
    @(posedge clk); #1;
    q.push_back('{1, {15'b0, i}, r});
    q.push_back('{2, {15'b0, w}, r});
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) chk_rd(3'(a), 16'h0000, "R1");
    chk_out(0, 0, "R1");
    // R2 flags latch without enables
    pulse(32'h0010_0008);
    chk_rd(3'd2, 16'h0008, "R2");
    chk_rd(3'd3, 16'h0010, "R2");
    chk_out(0, 0, "R2");
    // R5 wake without global enable; R3 readback
    wr(3'd0, 16'h0008);
    chk_rd(3'd0, 16'h0008, "R3");
    chk_out(0, 1, "R5");
    // R9 master bit only; R8/R4 irq after write
    wr(3'd4, 16'hFFFF);
    chk_rd(3'd4, 16'h0001, "R9");
    chk_out(1, 1, "R4 R8");
    // R6 w1c, R10 level drop
    wr(3'd2, 16'h0008);
    chk_rd(3'd2, 16'h0000, "R6");
    chk_out(0, 0, "R10");
    wr(3'd3, 16'h0000);
    chk_rd(3'd3, 16'h0010, "R6");
    // R8 enable write raises irq
    wr(3'd1, 16'h0010);
    chk_rd(3'd1, 16'h0010, "R3");
    chk_out(1, 1, "R8");
    // R10 master off drops irq, wake stays (R5)
    wr(3'd4, 16'h0000);
    chk_out(0, 1, "R10 R5");
    wr(3'd4, 16'h0001);
    chk_out(1, 1, "R4");
    // R7 set beats clear in same cycle
    @(posedge clk); #1 we = 1; addr = 3'd3; wdata = 16'h0010; src = 32'h0010_0000;
    @(posedge clk); #1 we = 0; src = '0;
    chk_rd(3'd3, 16'h0010, "R7");
    chk_out(1, 1, "R7");
    // R9 unmapped address
    wr(3'd5, 16'hFFFF);
    chk_rd(3'd5, 16'h0000, "R9");
    chk_rd(3'd0, 16'h0008, "R9");
    chk_rd(3'd1, 16'h0010, "R9");
    chk_rd(3'd4, 16'h0001, "R9");
    // R2 edge bits of both halves
    pulse(32'h8000_8000);
    chk_rd(3'd2, 16'h8000, "R2");
    chk_rd(3'd3, 16'h8010, "R2");
    // R10 clear all enabled pending -> irq and wake drop
    wr(3'd3, 16'hFFFF);
    chk_rd(3'd3, 16'h0000, "R6");
    chk_out(0, 0, "R10");
    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule